// File: doc/BRIEF.md
# UART Hardware Handshake Controller

This block performs the two-wire hardware handshake that sits beside a UART's serial engine. On the transmit side it watches the remote clear-to-send line and decides whether the transmitter may begin its next frame. The line is brought into the local clock domain through a flop synchronizer. It is then compared with a programmable stop level. When the two match, new frame starts are held back. A frame that has already started is never cut short, because only the start request is gated.

On the receive side it drives the request-to-send line to the remote sender. In automatic mode the line follows the receive FIFO occupancy compared with a programmable threshold, and an optional inversion can be applied. In manual mode software sets the line level directly. The transmit and receive halves each have their own enable. The RTS line is active low: 0 means "ready to receive".

Top module: `uart_handshake`

## Requirements
- R1: The CTS input passes through a two-flop synchronizer, so a change on `cts_in` reaches `tx_allow` on the second rising clock edge after it is applied and not on the first.
- R2: With `cts_en`=1, `tx_allow` is 0 while the synchronized CTS level equals `cts_stop_lvl` (either polarity 0 or 1), and 1 otherwise.
- R3: With `cts_en`=0, `tx_allow` is 1 whatever the CTS input and stop level are, taking effect in the same cycle.
- R4: `tx_start_ok` equals `tx_start_req` AND `tx_allow` in the same cycle, so only the start of a new frame is gated.
- R5: With `rts_en`=1 and `rts_mode`=0 (automatic), `rts_n` is registered and becomes 0 when `rx_count` < `rts_thresh` and 1 when `rx_count` >= `rts_thresh`, one clock edge after the inputs change (a threshold of 0 gives 1).
- R6: In automatic mode, `rts_inv`=1 flips the `rts_n` level that R5 gives.
- R7: With `rts_en`=1 and `rts_mode`=1 (manual), `rts_n` takes the value of `rts_sw_lvl` one edge later, and neither `rts_inv` nor `rx_count` has any effect.
- R8: With `rts_en`=0, `rts_n` is 0 (the ready level) one edge later, whatever the mode, inversion, threshold and count are.
- R9: During and after reset with the enables low, `rts_n` is 0 and `tx_allow` is 1. The synchronizer flops reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_in | input | 1 | Remote clear-to-send line, asynchronous |
| cts_en | input | 1 | Enables transmit gating by CTS |
| cts_stop_lvl | input | 1 | CTS level that holds transmission |
| tx_start_req | input | 1 | Transmitter asks to begin a new frame |
| tx_allow | output | 1 | New frame starts are permitted |
| tx_start_ok | output | 1 | Frame start granted this cycle |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rts_en | input | 1 | Enables RTS control |
| rts_mode | input | 1 | 0 = automatic, 1 = manual |
| rts_thresh | input | CNT_W | Occupancy at which automatic RTS goes not-ready |
| rts_inv | input | 1 | Inverts RTS in automatic mode |
| rts_sw_lvl | input | 1 | Software RTS level for manual mode |
| rts_n | output | 1 | Request-to-send line, active low |

## Verification
The CTS path has a two-edge latency. The bench therefore applies each new `cts_in` value on a falling edge, samples just after the first rising edge to confirm the old value still holds, and samples after the second rising edge for the new value. The `cts_en` and start-request paths are combinational, so they are checked a moment after the driving edge without waiting for a clock. `rts_n` comes from a single register. Every RTS stimulus is therefore applied on a falling edge and checked just after the next rising edge.

// File: rtl/uhs_pkg.sv
package uhs_pkg;

  localparam logic RTS_READY = 1'b0;

  typedef enum logic {
    RTS_AUTO   = 1'b0,
    RTS_MANUAL = 1'b1
  } rts_mode_e;

  // raw automatic level: ready below threshold, busy at or above it
  function automatic logic rts_auto_level(input logic [15:0] cnt,
                                          input logic [15:0] thr,
                                          input logic        inv);
    logic busy;
    busy = (cnt >= thr);
    return (busy ? ~RTS_READY : RTS_READY) ^ inv;
  endfunction

  function automatic logic cts_holds(input logic synced,
                                     input logic en,
                                     input logic stop_lvl);
    return en && (synced == stop_lvl);
  endfunction

endpackage

// File: rtl/uhs_sync.sv
module uhs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/uhs_cts_gate.sv
module uhs_cts_gate
  import uhs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_in,
  input  logic cts_en,
  input  logic cts_stop_lvl,
  input  logic tx_start_req,
  output logic tx_allow,
  output logic tx_start_ok
);
  logic cts_synced;
  logic hold_evt;

  uhs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (cts_in),
    .q    (cts_synced)
  );

  assign hold_evt    = cts_holds(cts_synced, cts_en, cts_stop_lvl);
  assign tx_allow    = ~hold_evt;
  assign tx_start_ok = tx_start_req & tx_allow;

  // R2: stop level held on the pin for the sync depth blocks transmit
  p_stop_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_en && $past(cts_in) == cts_stop_lvl && $past(cts_in, 2) == cts_stop_lvl
     && $past(rst_n, 2)) |-> !tx_allow);

  // R3: disabled CTS never blocks
  p_cts_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cts_en |-> tx_allow);

  // R4: no grant without a request
  p_grant_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_ok |-> (tx_start_req && tx_allow));

endmodule

// File: rtl/uhs_rts_drive.sv
module uhs_rts_drive
  import uhs_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rts_en,
  input  logic             rts_mode,
  input  logic [CNT_W-1:0] rts_thresh,
  input  logic             rts_inv,
  input  logic             rts_sw_lvl,
  output logic             rts_n
);
  localparam int PADW = 16 - CNT_W;

  rts_mode_e  mode_q;
  logic       auto_lvl;
  logic       next_lvl;

  assign mode_q   = rts_mode_e'(rts_mode);
  assign auto_lvl = rts_auto_level({{PADW{1'b0}}, rx_count},
                                   {{PADW{1'b0}}, rts_thresh}, rts_inv);

  always_comb begin
    if (!rts_en)                 next_lvl = RTS_READY;
    else if (mode_q == RTS_AUTO) next_lvl = auto_lvl;
    else                         next_lvl = rts_sw_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_n <= RTS_READY;
    else        rts_n <= next_lvl;
  end

  // R8: disabled output sits at ready
  p_off_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!rts_en)) |-> rts_n == RTS_READY);

  // R7: manual mode follows the software level
  p_manual_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rts_en && rts_mode)) |-> rts_n == $past(rts_sw_lvl));

  // R5: below threshold without inversion reports ready
  p_auto_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rts_en && !rts_mode && !rts_inv && rx_count < rts_thresh))
    |-> rts_n == 1'b0);

  // R6: inverted automatic level at or above threshold reads 0
  p_auto_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rts_en && !rts_mode && rts_inv && rx_count >= rts_thresh))
    |-> rts_n == 1'b0);

endmodule

// File: rtl/uart_handshake.sv
module uart_handshake #(
  parameter int CNT_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cts_in,
  input  logic             cts_en,
  input  logic             cts_stop_lvl,
  input  logic             tx_start_req,
  output logic             tx_allow,
  output logic             tx_start_ok,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rts_en,
  input  logic             rts_mode,
  input  logic [CNT_W-1:0] rts_thresh,
  input  logic             rts_inv,
  input  logic             rts_sw_lvl,
  output logic             rts_n
);

  uhs_cts_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk         (clk),
    .rst_n       (rst_n),
    .cts_in      (cts_in),
    .cts_en      (cts_en),
    .cts_stop_lvl(cts_stop_lvl),
    .tx_start_req(tx_start_req),
    .tx_allow    (tx_allow),
    .tx_start_ok (tx_start_ok)
  );

  uhs_rts_drive #(.CNT_W(CNT_W)) u_rts (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_count  (rx_count),
    .rts_en    (rts_en),
    .rts_mode  (rts_mode),
    .rts_thresh(rts_thresh),
    .rts_inv   (rts_inv),
    .rts_sw_lvl(rts_sw_lvl),
    .rts_n     (rts_n)
  );

  // R9: reset leaves the RTS line ready
  p_reset_ready_r9: assert property (@(posedge clk)
    !rst_n |-> rts_n == 1'b0);

endmodule

// File: tb/uart_handshake_bench.sv
module uart_handshake_bench;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_in = 1'b0, cts_en = 1'b0, cts_stop_lvl = 1'b0, tx_start_req = 1'b0;
  logic tx_allow, tx_start_ok;
  logic [CNT_W-1:0] rx_count = '0, rts_thresh = '0;
  logic rts_en = 1'b0, rts_mode = 1'b0, rts_inv = 1'b0, rts_sw_lvl = 1'b0;
  logic rts_n;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  uart_handshake #(.CNT_W(CNT_W)) u_uart_handshake (
    .clk(clk), .rst_n(rst_n), .cts_in(cts_in), .cts_en(cts_en),
    .cts_stop_lvl(cts_stop_lvl), .tx_start_req(tx_start_req),
    .tx_allow(tx_allow), .tx_start_ok(tx_start_ok), .rx_count(rx_count),
    .rts_en(rts_en), .rts_mode(rts_mode), .rts_thresh(rts_thresh),
    .rts_inv(rts_inv), .rts_sw_lvl(rts_sw_lvl), .rts_n(rts_n)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    #1;
    check("R9 rts during reset", rts_n, 1'b0);
    check("R9 allow during reset", tx_allow, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    after_edge();
    check("R9 rts after reset", rts_n, 1'b0);
    check("R9 allow after reset", tx_allow, 1'b1);
  endtask

  task automatic t_cts_stop_high();
    @(negedge clk); cts_en = 1'b1; cts_stop_lvl = 1'b1; cts_in = 1'b0;
    after_edge(); after_edge();
    check("R2 not at stop level", tx_allow, 1'b1);
    @(negedge clk); cts_in = 1'b1;
    after_edge();
    check("R1 one edge still old", tx_allow, 1'b1);
    after_edge();
    check("R1/R2 blocked after two edges", tx_allow, 1'b0);
    @(negedge clk); tx_start_req = 1'b1; #1;
    check("R4 request while blocked", tx_start_ok, 1'b0);
    @(negedge clk); cts_in = 1'b0;
    after_edge();
    check("R1 release one edge still held", tx_allow, 1'b0);
    after_edge();
    check("R1 released after two edges", tx_allow, 1'b1);
    check("R4 grant once allowed", tx_start_ok, 1'b1);
    @(negedge clk); tx_start_req = 1'b0; #1;
    check("R4 no request no grant", tx_start_ok, 1'b0);
  endtask

  task automatic t_cts_stop_low();
    @(negedge clk); cts_stop_lvl = 1'b0; #1;
    check("R2 polarity 0 blocks low line", tx_allow, 1'b0);
    @(negedge clk); cts_in = 1'b1;
    after_edge(); after_edge();
    check("R2 polarity 0 high line allowed", tx_allow, 1'b1);
    @(negedge clk); cts_in = 1'b0;
    after_edge(); after_edge();
    check("R2 polarity 0 low line blocked", tx_allow, 1'b0);
  endtask

  task automatic t_cts_off();
    @(negedge clk); cts_en = 1'b0; tx_start_req = 1'b1; #1;
    check("R3 disabled allows at stop level", tx_allow, 1'b1);
    check("R3/R4 grant with cts disabled", tx_start_ok, 1'b1);
    @(negedge clk); tx_start_req = 1'b0;
  endtask

  task automatic t_auto();
    @(negedge clk); rts_en = 1'b1; rts_mode = 1'b0; rts_inv = 1'b0;
    rts_thresh = 5'd8; rx_count = 5'd7;
    after_edge();
    check("R5 below threshold ready", rts_n, 1'b0);
    @(negedge clk); rx_count = 5'd8; #1;
    check("R5 registered, not yet", rts_n, 1'b0);
    after_edge();
    check("R5 at threshold busy", rts_n, 1'b1);
    @(negedge clk); rx_count = 5'd31;
    after_edge();
    check("R5 above threshold busy", rts_n, 1'b1);
    @(negedge clk); rts_thresh = 5'd0; rx_count = 5'd0;
    after_edge();
    check("R5 zero threshold busy", rts_n, 1'b1);
  endtask

  task automatic t_invert();
    @(negedge clk); rts_inv = 1'b1; rts_thresh = 5'd8; rx_count = 5'd3;
    after_edge();
    check("R6 inverted below threshold", rts_n, 1'b1);
    @(negedge clk); rx_count = 5'd9;
    after_edge();
    check("R6 inverted above threshold", rts_n, 1'b0);
  endtask

  task automatic t_manual();
    @(negedge clk); rts_mode = 1'b1; rts_inv = 1'b0; rts_sw_lvl = 1'b1; rx_count = 5'd0;
    after_edge();
    check("R7 manual high", rts_n, 1'b1);
    @(negedge clk); rts_sw_lvl = 1'b0; rx_count = 5'd20;
    after_edge();
    check("R7 manual low ignores count", rts_n, 1'b0);
    @(negedge clk); rts_sw_lvl = 1'b1; rts_inv = 1'b1;
    after_edge();
    check("R7 inversion ignored in manual", rts_n, 1'b1);
  endtask

  task automatic t_rts_off();
    @(negedge clk); rts_en = 1'b0;
    after_edge();
    check("R8 disabled manual high -> ready", rts_n, 1'b0);
    @(negedge clk); rts_mode = 1'b0; rts_inv = 1'b0; rts_thresh = 5'd2; rx_count = 5'd30;
    after_edge();
    check("R8 disabled auto over threshold -> ready", rts_n, 1'b0);
    @(negedge clk); rts_en = 1'b1;
    after_edge();
    check("R5 re-enabled over threshold busy", rts_n, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_cts_stop_high();
    t_cts_stop_low();
    t_cts_off();
    t_auto();
    t_invert();
    t_manual();
    t_rts_off();
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule